// File: doc/BRIEF.md
# Inclusive middle-level coherence line controller

This block is the decision core of a private middle-level cache that keeps a MESI copy of each line and is inclusive of a smaller inner cache. Every cycle it is handed one already-classified event, together with the current coherence state of the line that event concerns. It answers in the same cycle with the line's next state and a vector of action strobes. The event comes from the inner cache, from the shared outer cache, or from the local replacement logic. The surrounding cache pipeline performs the actions and writes the next state back into the tag array. The data array, the tag lookup and the network transport all live outside this block.

Each stable state comes in two forms. In one form the inner cache also holds the line, and in the other only this level holds it. Outer traffic that finds the line in an inner-present form is first turned into an invalidation of the inner cache. A set of waiting states then parks the line until the inner cache replies. Misses, upgrades and writebacks pass through transient states that count acks, absorb races with invalidations, and hold a buffered copy for late forwarded requests. A pair of state and event for which no transition is defined raises a sticky protocol-error flag, and the line is left untouched.

Top module: `mlc_line_ctrl`

## Requirements
- R1: Encodings. States: NP=0, I=1, S=2 (inner holds), SS=3 (local only), E=4, EE=5, M=6, MM=7, IS=8, IM=9, SM=10, IS_I=11, M_I=12, SINK_WB_ACK=13. The states waiting for the inner cache are S_W=14, E_W=15, M_W=16, MM_W=17 and SM_W=18. Codes 19 to 31 are unused. Events: LOAD=0, STORE=1, WRITEBACK=2, INNER_DATA_ACK=3, INNER_ACK=4, INV=5, EVICT_OWN=6, EVICT_OTHER=7, REPLACE=8, FWD_GETX=9, FWD_GETS=10, DATA=11, DATA_EXCL=12, DATA_PEER=13, DATA_LAST=14, ACK=15, ACK_LAST=16, WB_ACK=17. Codes 18 to 31 are unused. Action bits: GETS=0, GETX=1, UPGRADE=2, PUTX=3, DATA_TO_REQ=4, DATA_TO_OUTER=5, ACK_TO_OUTER=6, DATA_TO_INNER=7, XDATA_TO_INNER=8, STALE_TO_INNER=9, INV_TO_INNER=10, UNBLOCK=11, XUNBLOCK=12, BUF_ALLOC=13, BUF_FREE=14, LINE_ALLOC=15, LINE_FREE=16, WRITE_LINE=17, SET_DIRTY=18, ACK_COUNT=19, POP_INNER=20, POP_REQ=21, POP_RSP=22, STALL=23, WAKE=24. While ev_valid_i is low, all strobes are zero and the next state equals the current state. Reset clears the error flag.
- R2: In NP or I, LOAD goes to IS and STORE goes to IM. Each raises BUF_ALLOC, LINE_ALLOC and POP_INNER, plus GETS or GETX respectively. STORE in S or SS goes to SM with UPGRADE, BUF_ALLOC and POP_INNER.
- R3: LOAD in S or SS goes to S with DATA_TO_INNER and POP_INNER. LOAD in EE goes to E, and LOAD in MM goes to M, each with XDATA_TO_INNER and POP_INNER. STORE in EE or MM goes to M with XDATA_TO_INNER, SET_DIRTY and POP_INNER.
- R4: REPLACE in EE or MM goes to M_I with PUTX, BUF_ALLOC and LINE_FREE. REPLACE in SS goes to I with LINE_FREE. REPLACE in NP or I stays put with LINE_FREE. WRITEBACK in E or M goes to MM with WRITE_LINE and POP_INNER.
- R5: In M_I, FWD_GETX gives DATA_TO_REQ and FWD_GETS gives DATA_TO_REQ and DATA_TO_OUTER. INV gives DATA_TO_OUTER. Each of these goes to SINK_WB_ACK with POP_REQ. INV in SINK_WB_ACK stays there with ACK_TO_OUTER and POP_REQ. WB_ACK in M_I or SINK_WB_ACK goes to I with BUF_FREE, POP_RSP and WAKE.
- R6: In EE or MM, FWD_GETS goes to SS with DATA_TO_REQ, DATA_TO_OUTER and POP_REQ. FWD_GETX goes to I with DATA_TO_REQ, LINE_FREE and POP_REQ. INV goes to I with LINE_FREE and POP_REQ, plus ACK_TO_OUTER in EE or DATA_TO_OUTER in MM. INV in SS goes to I with ACK_TO_OUTER, LINE_FREE and POP_REQ. INV in NP or I stays put with ACK_TO_OUTER and POP_REQ.
- R7: INV in IS or IS_I goes to IS_I with ACK_TO_OUTER and POP_REQ. DATA_LAST or DATA_PEER in IS_I goes to I with STALE_TO_INNER, and the same events in IS go to S with DATA_TO_INNER. All four carry WRITE_LINE, BUF_FREE, POP_RSP and WAKE, and the DATA_PEER cases add UNBLOCK.
- R8: DATA_EXCL in IS or IS_I goes to E. DATA_LAST in IM goes to M. Both give WRITE_LINE, XDATA_TO_INNER, XUNBLOCK, BUF_FREE, POP_RSP and WAKE. ACK_LAST in SM goes to M with the same set except WRITE_LINE. DATA in IM goes to SM with WRITE_LINE, ACK_COUNT and POP_RSP. ACK in IM or SM holds the state with ACK_COUNT and POP_RSP. INV in IM or SM goes to IM with ACK_TO_OUTER and POP_REQ.
- R9: EVICT_OWN or EVICT_OTHER moves S, E and M to S_W, E_W and M_W respectively, with INV_TO_INNER only. INNER_ACK moves S_W to SS, E_W to EE, M_W and MM_W to MM, and SM_W to IM, with POP_INNER and WAKE. INNER_DATA_ACK does the same with WRITE_LINE added, except that E_W goes to MM. WRITEBACK in E_W or M_W goes to MM_W with WRITE_LINE and POP_INNER.
- R10: LOAD, STORE and REPLACE in any transient or waiting state give STALL alone. INV, FWD_GETX, FWD_GETS, EVICT_OWN and EVICT_OTHER in any waiting state give STALL alone. A stalled event keeps the state.
- R11: Any other pair of state and event, unused codes included, gives no strobes and keeps the state. One cycle later the protocol-error flag is high, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the error flag |
| ev_valid_i | input | 1 | An event is presented this cycle |
| ev_code_i | input | EV_W (5) | Classified event code |
| cur_state_i | input | ST_W (5) | Current coherence state of the addressed line |
| nxt_state_o | output | ST_W (5) | State to write back for the line |
| act_o | output | 25 | One strobe per action, valid in the event's cycle |
| proto_err_o | output | 1 | Sticky flag for an undefined state/event pair |

## Verification
The bench drives all 32 state codes against all 32 event codes. Each result is compared with a rule table written per requirement, so any single mistake in the decode shows up. A likely example is an EE read that ends in M instead of E, which would silently make the inner copy writable. Another is a forwarded GETX in M_I that forgets the buffered copy and leaves the line stuck in M_I. The stale delivery after an invalidation that races a pending GETS is checked directly. So is the E_W reply with data, which must land in MM rather than EE, or dirty data would be lost. The error flag is checked for staying low through idle cycles and legal events, and for latching on the first illegal pair until reset.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

   localparam int ST_BITS = 5;
   localparam int EV_BITS = 5;
   localparam int ACT_N   = 25;

   typedef enum logic [ST_BITS-1:0] {
      ST_NP   = 5'd0,
      ST_I    = 5'd1,
      ST_SH   = 5'd2,
      ST_SHL  = 5'd3,
      ST_EX   = 5'd4,
      ST_EXL  = 5'd5,
      ST_MD   = 5'd6,
      ST_MDL  = 5'd7,
      ST_IS   = 5'd8,
      ST_IM   = 5'd9,
      ST_SM   = 5'd10,
      ST_ISI  = 5'd11,
      ST_MI   = 5'd12,
      ST_SINK = 5'd13,
      ST_SHW  = 5'd14,
      ST_EXW  = 5'd15,
      ST_MDW  = 5'd16,
      ST_MDLW = 5'd17,
      ST_SMW  = 5'd18
   } state_e;

   typedef enum logic [EV_BITS-1:0] {
      EV_LOAD        = 5'd0,
      EV_STORE       = 5'd1,
      EV_WRBACK      = 5'd2,
      EV_IN_DACK     = 5'd3,
      EV_IN_ACK      = 5'd4,
      EV_INV         = 5'd5,
      EV_EVICT_OWN   = 5'd6,
      EV_EVICT_OTHER = 5'd7,
      EV_REPL        = 5'd8,
      EV_FWD_EXCL    = 5'd9,
      EV_FWD_SHR     = 5'd10,
      EV_DATA        = 5'd11,
      EV_DATA_EXCL   = 5'd12,
      EV_DATA_PEER   = 5'd13,
      EV_DATA_LAST   = 5'd14,
      EV_ACK         = 5'd15,
      EV_ACK_LAST    = 5'd16,
      EV_WB_ACK      = 5'd17
   } event_e;

   typedef logic [ACT_N-1:0] act_t;

   localparam int A_GETS    = 0;
   localparam int A_GETX    = 1;
   localparam int A_UPGR    = 2;
   localparam int A_PUTX    = 3;
   localparam int A_DREQ    = 4;
   localparam int A_DOUT    = 5;
   localparam int A_OACK    = 6;
   localparam int A_DIN     = 7;
   localparam int A_XDIN    = 8;
   localparam int A_STALE   = 9;
   localparam int A_INVIN   = 10;
   localparam int A_UNBLK   = 11;
   localparam int A_XUNBLK  = 12;
   localparam int A_TALLOC  = 13;
   localparam int A_TFREE   = 14;
   localparam int A_LALLOC  = 15;
   localparam int A_LFREE   = 16;
   localparam int A_WRLINE  = 17;
   localparam int A_DIRTY   = 18;
   localparam int A_ACKCNT  = 19;
   localparam int A_POPIN   = 20;
   localparam int A_POPREQ  = 21;
   localparam int A_POPRSP  = 22;
   localparam int A_STALL   = 23;
   localparam int A_WAKE    = 24;

endpackage

// File: rtl/mlc_next_state.sv
module mlc_next_state
   import mlc_pkg::*;
(
   input  logic   valid_i,
   input  state_e st_i,
   input  event_e ev_i,
   output state_e nxt_o,
   output logic   legal_o
);

   logic waiting;
   logic busy;

   assign waiting = st_i inside {ST_SHW, ST_EXW, ST_MDW, ST_MDLW, ST_SMW};
   assign busy    = waiting | (st_i inside {ST_IS, ST_IM, ST_SM, ST_ISI, ST_MI, ST_SINK});

   always_comb begin
      nxt_o   = st_i;
      legal_o = 1'b0;
      if (valid_i) begin
         case (ev_i)
            EV_LOAD: begin
               legal_o = 1'b1;
               if (st_i inside {ST_NP, ST_I})        nxt_o = ST_IS;
               else if (st_i inside {ST_SH, ST_SHL}) nxt_o = ST_SH;
               else if (st_i == ST_EXL)              nxt_o = ST_EX;
               else if (st_i == ST_MDL)              nxt_o = ST_MD;
               else if (!busy)                       legal_o = 1'b0;
            end
            EV_STORE: begin
               legal_o = 1'b1;
               if (st_i inside {ST_NP, ST_I})          nxt_o = ST_IM;
               else if (st_i inside {ST_SH, ST_SHL})   nxt_o = ST_SM;
               else if (st_i inside {ST_EXL, ST_MDL})  nxt_o = ST_MD;
               else if (!busy)                         legal_o = 1'b0;
            end
            EV_REPL: begin
               legal_o = 1'b1;
               if (st_i == ST_SHL)                     nxt_o = ST_I;
               else if (st_i inside {ST_EXL, ST_MDL})  nxt_o = ST_MI;
               else if (!(busy || st_i inside {ST_NP, ST_I})) legal_o = 1'b0;
            end
            EV_WRBACK: begin
               legal_o = 1'b1;
               if (st_i inside {ST_EX, ST_MD})         nxt_o = ST_MDL;
               else if (st_i inside {ST_EXW, ST_MDW})  nxt_o = ST_MDLW;
               else                                    legal_o = 1'b0;
            end
            EV_IN_DACK, EV_IN_ACK: begin
               legal_o = waiting;
               case (st_i)
                  ST_SHW:          nxt_o = ST_SHL;
                  ST_EXW:          nxt_o = (ev_i == EV_IN_DACK) ? ST_MDL : ST_EXL;
                  ST_MDW, ST_MDLW: nxt_o = ST_MDL;
                  ST_SMW:          nxt_o = ST_IM;
                  default:         nxt_o = st_i;
               endcase
            end
            EV_INV: begin
               legal_o = 1'b1;
               case (st_i)
                  ST_SHL, ST_EXL, ST_MDL: nxt_o = ST_I;
                  ST_MI:                  nxt_o = ST_SINK;
                  ST_IS, ST_ISI:          nxt_o = ST_ISI;
                  ST_IM, ST_SM:           nxt_o = ST_IM;
                  ST_NP, ST_I, ST_SINK:   nxt_o = st_i;
                  default:                legal_o = waiting;
               endcase
            end
            EV_EVICT_OWN, EV_EVICT_OTHER: begin
               legal_o = 1'b1;
               case (st_i)
                  ST_SH:   nxt_o = ST_SHW;
                  ST_EX:   nxt_o = ST_EXW;
                  ST_MD:   nxt_o = ST_MDW;
                  default: legal_o = waiting;
               endcase
            end
            EV_FWD_EXCL, EV_FWD_SHR: begin
               legal_o = 1'b1;
               if (st_i inside {ST_EXL, ST_MDL})
                  nxt_o = (ev_i == EV_FWD_EXCL) ? ST_I : ST_SHL;
               else if (st_i == ST_MI) nxt_o = ST_SINK;
               else                    legal_o = waiting;
            end
            EV_DATA: begin
               legal_o = (st_i == ST_IM);
               if (legal_o) nxt_o = ST_SM;
            end
            EV_DATA_EXCL: begin
               legal_o = st_i inside {ST_IS, ST_ISI};
               if (legal_o) nxt_o = ST_EX;
            end
            EV_DATA_PEER, EV_DATA_LAST: begin
               legal_o = 1'b1;
               if (st_i == ST_IS)                           nxt_o = ST_SH;
               else if (st_i == ST_ISI)                     nxt_o = ST_I;
               else if (st_i == ST_IM && ev_i == EV_DATA_LAST) nxt_o = ST_MD;
               else                                         legal_o = 1'b0;
            end
            EV_ACK:      legal_o = st_i inside {ST_IM, ST_SM};
            EV_ACK_LAST: begin
               legal_o = (st_i == ST_SM);
               if (legal_o) nxt_o = ST_MD;
            end
            EV_WB_ACK: begin
               legal_o = st_i inside {ST_MI, ST_SINK};
               if (legal_o) nxt_o = ST_I;
            end
            default: legal_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/mlc_action_gen.sv
module mlc_action_gen
   import mlc_pkg::*;
(
   input  logic   valid_i,
   input  state_e st_i,
   input  event_e ev_i,
   output act_t   act_o
);

   logic waiting;
   logic busy;
   logic idle;

   assign waiting = st_i inside {ST_SHW, ST_EXW, ST_MDW, ST_MDLW, ST_SMW};
   assign busy    = waiting | (st_i inside {ST_IS, ST_IM, ST_SM, ST_ISI, ST_MI, ST_SINK});
   assign idle    = st_i inside {ST_NP, ST_I};

   always_comb begin
      act_o = '0;
      if (valid_i) begin
         case (ev_i)
            EV_LOAD, EV_STORE: begin
               if (idle) begin
                  act_o[(ev_i == EV_LOAD) ? A_GETS : A_GETX] = 1'b1;
                  act_o[A_LALLOC] = 1'b1;
                  act_o[A_TALLOC] = 1'b1;
                  act_o[A_POPIN]  = 1'b1;
               end else if (st_i inside {ST_SH, ST_SHL}) begin
                  act_o[A_POPIN] = 1'b1;
                  if (ev_i == EV_LOAD) act_o[A_DIN] = 1'b1;
                  else begin
                     act_o[A_UPGR]   = 1'b1;
                     act_o[A_TALLOC] = 1'b1;
                  end
               end else if (st_i inside {ST_EXL, ST_MDL}) begin
                  act_o[A_XDIN]  = 1'b1;
                  act_o[A_POPIN] = 1'b1;
                  act_o[A_DIRTY] = (ev_i == EV_STORE);
               end else if (busy) begin
                  act_o[A_STALL] = 1'b1;
               end
            end
            EV_REPL: begin
               if (idle || st_i == ST_SHL) act_o[A_LFREE] = 1'b1;
               else if (st_i inside {ST_EXL, ST_MDL}) begin
                  act_o[A_TALLOC] = 1'b1;
                  act_o[A_PUTX]   = 1'b1;
                  act_o[A_LFREE]  = 1'b1;
               end else if (busy) act_o[A_STALL] = 1'b1;
            end
            EV_WRBACK: begin
               if (st_i inside {ST_EX, ST_MD, ST_EXW, ST_MDW}) begin
                  act_o[A_WRLINE] = 1'b1;
                  act_o[A_POPIN]  = 1'b1;
               end
            end
            EV_IN_DACK, EV_IN_ACK: begin
               if (waiting) begin
                  act_o[A_WRLINE] = (ev_i == EV_IN_DACK);
                  act_o[A_POPIN]  = 1'b1;
                  act_o[A_WAKE]   = 1'b1;
               end
            end
            EV_INV: begin
               case (st_i)
                  ST_NP, ST_I, ST_SINK, ST_IS, ST_ISI, ST_IM, ST_SM: begin
                     act_o[A_OACK]   = 1'b1;
                     act_o[A_POPREQ] = 1'b1;
                  end
                  ST_SHL, ST_EXL: begin
                     act_o[A_OACK]   = 1'b1;
                     act_o[A_LFREE]  = 1'b1;
                     act_o[A_POPREQ] = 1'b1;
                  end
                  ST_MDL, ST_MI: begin
                     act_o[A_DOUT]   = 1'b1;
                     act_o[A_LFREE]  = (st_i == ST_MDL);
                     act_o[A_POPREQ] = 1'b1;
                  end
                  default: act_o[A_STALL] = waiting;
               endcase
            end
            EV_EVICT_OWN, EV_EVICT_OTHER: begin
               if (st_i inside {ST_SH, ST_EX, ST_MD}) act_o[A_INVIN] = 1'b1;
               else act_o[A_STALL] = waiting;
            end
            EV_FWD_EXCL, EV_FWD_SHR: begin
               if (st_i inside {ST_EXL, ST_MDL, ST_MI}) begin
                  act_o[A_DREQ]   = 1'b1;
                  act_o[A_POPREQ] = 1'b1;
                  act_o[A_DOUT]   = (ev_i == EV_FWD_SHR);
                  act_o[A_LFREE]  = (ev_i == EV_FWD_EXCL) && (st_i != ST_MI);
               end else act_o[A_STALL] = waiting;
            end
            EV_DATA: begin
               if (st_i == ST_IM) begin
                  act_o[A_WRLINE] = 1'b1;
                  act_o[A_ACKCNT] = 1'b1;
                  act_o[A_POPRSP] = 1'b1;
               end
            end
            EV_ACK: begin
               if (st_i inside {ST_IM, ST_SM}) begin
                  act_o[A_ACKCNT] = 1'b1;
                  act_o[A_POPRSP] = 1'b1;
               end
            end
            EV_DATA_EXCL, EV_DATA_PEER, EV_DATA_LAST, EV_ACK_LAST: begin
               if ((ev_i == EV_DATA_EXCL && st_i inside {ST_IS, ST_ISI}) ||
                   (ev_i == EV_DATA_LAST && st_i == ST_IM) ||
                   (ev_i == EV_ACK_LAST && st_i == ST_SM)) begin
                  act_o[A_WRLINE] = (ev_i != EV_ACK_LAST);
                  act_o[A_XDIN]   = 1'b1;
                  act_o[A_XUNBLK] = 1'b1;
                  act_o[A_TFREE]  = 1'b1;
                  act_o[A_POPRSP] = 1'b1;
                  act_o[A_WAKE]   = 1'b1;
               end else if (ev_i != EV_DATA_EXCL && ev_i != EV_ACK_LAST &&
                            st_i inside {ST_IS, ST_ISI}) begin
                  act_o[A_WRLINE] = 1'b1;
                  act_o[A_UNBLK]  = (ev_i == EV_DATA_PEER);
                  act_o[A_DIN]    = (st_i == ST_IS);
                  act_o[A_STALE]  = (st_i == ST_ISI);
                  act_o[A_TFREE]  = 1'b1;
                  act_o[A_POPRSP] = 1'b1;
                  act_o[A_WAKE]   = 1'b1;
               end
            end
            EV_WB_ACK: begin
               if (st_i inside {ST_MI, ST_SINK}) begin
                  act_o[A_TFREE]  = 1'b1;
                  act_o[A_POPRSP] = 1'b1;
                  act_o[A_WAKE]   = 1'b1;
               end
            end
            default: act_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/mlc_err_flag.sv
module mlc_err_flag #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_i,
   output logic err_o
);

   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n)     err_o <= 1'b0;
            else if (bad_i) err_o <= 1'b1;
         end

         // R11
         err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_o |=> err_o)
            else $error("error flag dropped without reset");
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= bad_i;
         end
      end
   endgenerate

   // R11
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_i |=> err_o)
      else $error("illegal event did not raise the error flag");

endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
   import mlc_pkg::*;
#(
   parameter int ST_W       = 5,
   parameter int EV_W       = 5,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid_i,
   input  logic [EV_W-1:0]   ev_code_i,
   input  logic [ST_W-1:0]   cur_state_i,
   output logic [ST_W-1:0]   nxt_state_o,
   output logic [ACT_N-1:0]  act_o,
   output logic              proto_err_o
);

   localparam logic [ST_BITS-1:0] ST_UNUSED = '1;
   localparam logic [EV_BITS-1:0] EV_UNUSED = '1;

   logic               st_hi;
   logic               ev_hi;
   logic [ST_BITS-1:0] st_raw;
   logic [EV_BITS-1:0] ev_raw;
   state_e             st;
   event_e             ev;
   state_e             nxt_st;
   logic               legal;
   act_t               acts;
   logic               take;

   generate
      if (ST_W < ST_BITS) begin : g_st_bad
         $error("ST_W is too narrow for the state encoding");
      end else if (ST_W > ST_BITS) begin : g_st_wide
         assign st_hi       = |cur_state_i[ST_W-1:ST_BITS];
         assign nxt_state_o = take ? {{(ST_W-ST_BITS){1'b0}}, nxt_st} : cur_state_i;
      end else begin : g_st_exact
         assign st_hi       = 1'b0;
         assign nxt_state_o = take ? nxt_st : cur_state_i;
      end

      if (EV_W < EV_BITS) begin : g_ev_bad
         $error("EV_W is too narrow for the event encoding");
      end else if (EV_W > EV_BITS) begin : g_ev_wide
         assign ev_hi = |ev_code_i[EV_W-1:EV_BITS];
      end else begin : g_ev_exact
         assign ev_hi = 1'b0;
      end
   endgenerate

   assign st_raw = st_hi ? ST_UNUSED : cur_state_i[ST_BITS-1:0];
   assign ev_raw = ev_hi ? EV_UNUSED : ev_code_i[EV_BITS-1:0];
   assign st     = state_e'(st_raw);
   assign ev     = event_e'(ev_raw);
   assign take   = ev_valid_i & legal;

   mlc_next_state u_next (
      .valid_i (ev_valid_i),
      .st_i    (st),
      .ev_i    (ev),
      .nxt_o   (nxt_st),
      .legal_o (legal)
   );

   mlc_action_gen u_act (
      .valid_i (ev_valid_i),
      .st_i    (st),
      .ev_i    (ev),
      .act_o   (acts)
   );

   mlc_err_flag #(.STICKY(ERR_STICKY)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .bad_i (ev_valid_i & ~legal),
      .err_o (proto_err_o)
   );

   assign act_o = acts;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid_i |-> (act_o == '0))
      else $error("strobes raised with no event");

   // R11
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && !legal) |-> (acts == '0))
      else $error("strobes raised for an undefined event");

   // R11
   legal_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && legal) |-> (acts != '0))
      else $error("defined transition raised no action");

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acts[A_STALL] |-> (nxt_st == st) && $countones(acts) == 1)
      else $error("stall changed state or came with other actions");

   // R10
   single_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acts[A_POPIN], acts[A_POPREQ], acts[A_POPRSP], acts[A_STALL]}))
      else $error("more than one queue action");

   // R2
   buf_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acts[A_TALLOC] |-> (nxt_st inside {ST_IS, ST_IM, ST_SM, ST_MI}))
      else $error("buffer allocated without entering a transient state");

   // R8
   xunblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acts[A_XUNBLK] |-> (nxt_st inside {ST_EX, ST_MD}))
      else $error("exclusive unblock outside an exclusive fill");

endmodule

// File: tb/mlc_line_ctrl_tb.sv
module mlc_line_ctrl_tb;

   localparam int NP=0, I=1, S=2, SS=3, E=4, EE=5, M=6, MM=7, IS=8, IM=9,
                  SM=10, ISI=11, MI=12, SK=13, SW=14, EW=15, MW=16, MMW=17, SMW=18;
   localparam int LD=0, STO=1, WB=2, IDA=3, IA=4, INV=5, EVO=6, EVE=7, REP=8,
                  FGX=9, FGS=10, DAT=11, DEX=12, DPR=13, DLS=14, ACK=15, ACL=16, WBA=17;
   localparam int GETS=0, GETX=1, UPG=2, PUTX=3, DREQ=4, DOUT=5, OACK=6, DIN=7,
                  XDIN=8, STALE=9, INVIN=10, UNB=11, XUNB=12, TAL=13, TFR=14,
                  LAL=15, LFR=16, WRL=17, DRT=18, ACN=19, POPI=20, POPQ=21,
                  POPR=22, STL=23, WAK=24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [4:0]  ev_code = '0;
   logic [4:0]  cur_state = '0;
   logic [4:0]  nxt_state;
   logic [24:0] act;
   logic        perr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mlc_line_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_valid_i  (ev_valid),
      .ev_code_i   (ev_code),
      .cur_state_i (cur_state),
      .nxt_state_o (nxt_state),
      .act_o       (act),
      .proto_err_o (perr)
   );

   function automatic logic [24:0] b(input int k);
      return 25'd1 << k;
   endfunction

   function automatic void model(input int s, input int e, output int nx,
                                 output logic [24:0] a, output string tg);
      logic [24:0] xfill;
      logic [24:0] sfill;
      bit inner_req;
      bit outer_req;
      xfill = b(XDIN) | b(XUNB) | b(TFR) | b(POPR) | b(WAK);
      sfill = b(WRL) | b(TFR) | b(POPR) | b(WAK);
      inner_req = (e == LD || e == STO || e == REP);
      outer_req = (e == INV || e == FGX || e == FGS || e == EVO || e == EVE);
      nx = s; a = '0; tg = "R11";
      if (s >= IS && s <= SMW && inner_req) begin
         a = b(STL); tg = "R10";
      end else if (s >= SW && s <= SMW && outer_req) begin
         a = b(STL); tg = "R10";
      end else begin
         case (s)
            NP, I: begin
               if (e == LD)       begin nx = IS; a = b(GETS)|b(LAL)|b(TAL)|b(POPI); tg = "R2"; end
               else if (e == STO) begin nx = IM; a = b(GETX)|b(LAL)|b(TAL)|b(POPI); tg = "R2"; end
               else if (e == REP) begin a = b(LFR); tg = "R4"; end
               else if (e == INV) begin a = b(OACK)|b(POPQ); tg = "R6"; end
            end
            S, SS: begin
               if (e == LD)       begin nx = S; a = b(DIN)|b(POPI); tg = "R3"; end
               else if (e == STO) begin nx = SM; a = b(UPG)|b(TAL)|b(POPI); tg = "R2"; end
               else if (s == S && (e == EVO || e == EVE)) begin nx = SW; a = b(INVIN); tg = "R9"; end
               else if (s == SS && e == REP) begin nx = I; a = b(LFR); tg = "R4"; end
               else if (s == SS && e == INV) begin nx = I; a = b(OACK)|b(LFR)|b(POPQ); tg = "R6"; end
            end
            E, M: begin
               if (e == WB) begin nx = MM; a = b(WRL)|b(POPI); tg = "R4"; end
               else if (e == EVO || e == EVE) begin nx = (s == E) ? EW : MW; a = b(INVIN); tg = "R9"; end
            end
            EE, MM: begin
               if (e == LD)       begin nx = (s == EE) ? E : M; a = b(XDIN)|b(POPI); tg = "R3"; end
               else if (e == STO) begin nx = M; a = b(XDIN)|b(DRT)|b(POPI); tg = "R3"; end
               else if (e == REP) begin nx = MI; a = b(PUTX)|b(TAL)|b(LFR); tg = "R4"; end
               else if (e == FGS) begin nx = SS; a = b(DREQ)|b(DOUT)|b(POPQ); tg = "R6"; end
               else if (e == FGX) begin nx = I; a = b(DREQ)|b(LFR)|b(POPQ); tg = "R6"; end
               else if (e == INV) begin
                  nx = I; a = b(LFR)|b(POPQ)|((s == EE) ? b(OACK) : b(DOUT)); tg = "R6";
               end
            end
            IS, ISI: begin
               if (e == INV)      begin nx = ISI; a = b(OACK)|b(POPQ); tg = "R7"; end
               else if (e == DEX) begin nx = E; a = xfill | b(WRL); tg = "R8"; end
               else if (e == DLS || e == DPR) begin
                  nx = (s == IS) ? S : I;
                  a = sfill | ((s == IS) ? b(DIN) : b(STALE)) | ((e == DPR) ? b(UNB) : '0);
                  tg = "R7";
               end
            end
            IM, SM: begin
               if (e == INV)      begin nx = IM; a = b(OACK)|b(POPQ); tg = "R8"; end
               else if (e == ACK) begin a = b(ACN)|b(POPR); tg = "R8"; end
               else if (s == IM && e == DAT) begin nx = SM; a = b(WRL)|b(ACN)|b(POPR); tg = "R8"; end
               else if (s == IM && e == DLS) begin nx = M; a = xfill | b(WRL); tg = "R8"; end
               else if (s == SM && e == ACL) begin nx = M; a = xfill; tg = "R8"; end
            end
            MI: begin
               if (e == INV)      begin nx = SK; a = b(DOUT)|b(POPQ); tg = "R5"; end
               else if (e == FGX) begin nx = SK; a = b(DREQ)|b(POPQ); tg = "R5"; end
               else if (e == FGS) begin nx = SK; a = b(DREQ)|b(DOUT)|b(POPQ); tg = "R5"; end
               else if (e == WBA) begin nx = I; a = b(TFR)|b(POPR)|b(WAK); tg = "R5"; end
            end
            SK: begin
               if (e == INV)      begin a = b(OACK)|b(POPQ); tg = "R5"; end
               else if (e == WBA) begin nx = I; a = b(TFR)|b(POPR)|b(WAK); tg = "R5"; end
            end
            SW, EW, MW, MMW, SMW: begin
               if (e == IA || e == IDA) begin
                  case (s)
                     SW:      nx = SS;
                     EW:      nx = (e == IDA) ? MM : EE;
                     SMW:     nx = IM;
                     default: nx = MM;
                  endcase
                  a = b(POPI) | b(WAK) | ((e == IDA) ? b(WRL) : '0); tg = "R9";
               end else if (e == WB && (s == EW || s == MW)) begin
                  nx = MMW; a = b(WRL)|b(POPI); tg = "R9";
               end
            end
            default: ;
         endcase
      end
   endfunction

   task automatic check(input string tg, input string what, input logic [31:0] got,
                        input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tg, what, got, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int nx;
      logic [24:0] ea;
      string tg;
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "error flag in reset", 32'(perr), 0);
      rst_n = 1'b1;

      // R1 no event: no strobes, state held, no error
      for (int s = 0; s < 32; s++) begin
         @(negedge clk);
         cur_state = 5'(s);
         ev_code   = 5'(31 - s);
         #1;
         check("R1", "idle state", 32'(nxt_state), 32'(s));
         check("R1", "idle strobes", 32'(act), 0);
      end
      @(negedge clk);
      check("R11", "flag low after idle cycles", 32'(perr), 0);

      // R2 legal event leaves the flag low
      cur_state = 5'(NP); ev_code = 5'(LD); ev_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
      @(negedge clk);
      check("R11", "flag low after legal event", 32'(perr), 0);

      // Full sweep of every state against every event
      for (int s = 0; s < 32; s++) begin
         for (int e = 0; e < 32; e++) begin
            @(negedge clk);
            cur_state = 5'(s);
            ev_code   = 5'(e);
            ev_valid  = 1'b1;
            #1;
            model(s, e, nx, ea, tg);
            checks++;
            if (nxt_state !== 5'(nx) || act !== ea) begin
               failures++;
               $display("FAIL %s state=%0d event=%0d: actual=%0d/%07h expected=%0d/%07h",
                        tg, s, e, nxt_state, act, nx, ea);
            end
         end
      end
      @(negedge clk);
      ev_valid = 1'b0;
      @(negedge clk);
      check("R11", "flag set after sweep", 32'(perr), 1);
      repeat (4) @(negedge clk);
      check("R11", "flag sticky", 32'(perr), 1);

      // R11 single illegal event after a fresh reset
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "reset clears flag", 32'(perr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cur_state = 5'(SS); ev_code = 5'(WBA); ev_valid = 1'b1;
      #1;
      check("R11", "illegal keeps state", 32'(nxt_state), 32'(SS));
      check("R11", "illegal strobes", 32'(act), 0);
      check("R11", "flag not yet set", 32'(perr), 0);
      @(negedge clk);
      ev_valid = 1'b0;
      check("R11", "flag one cycle later", 32'(perr), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule